// File: doc/BRIEF.md
# Real-Time Clock Tick Trimmer

This block turns a 32768 Hz reference enable into a once-per-second tick enable and trims the tick rate by a signed correction held in a calibration register. It does this by shortening or lengthening one tick period out of every few, measured in reference cycles. A positive correction means the reference oscillator runs slow, so ticks are made to come sooner. A negative correction makes them come later. The seconds counter that consumes the tick and the bus that writes the register sit outside the block. The block itself only sees a one-cycle write strobe with data.

The calibration word has three parts. Bits 7:0 hold a two's-complement offset. Bit 15 selects the step size: clear means fine steps, set means coarse steps. Bits 14:8 must carry a fill pattern that depends on the sign of the offset. When the fill is wrong, a sticky error flag is raised, but the offset still takes effect. A new word is captured at once, yet it only governs tick periods that start after the next tick. With the default parameters, fine mode adjusts one tick in 32 by the offset in reference cycles, which is about 954 ppb per step. Coarse mode adjusts one tick in 8, about 3815 ppb per step.

Top module: `rtc_trim`

## Requirements
- R1: While rst_n is low at a clock edge, the next cycle shows cal_rdata = 16'h2000 (nominal, zero offset), sec_tick = 0 and fill_err = 0.
- R2: A write (cal_we high at an edge) makes cal_rdata equal all 16 bits of cal_wdata from the next cycle on.
- R3: With offset bits 7:0 equal to zero, every tick period spans exactly CYC_PER_TICK reference enables.
- R4: In fine mode (bit 15 = 0), every FINE_TICKS-th tick period spans CYC_PER_TICK - offset reference enables and the others span CYC_PER_TICK.
- R5: In coarse mode (bit 15 = 1), every COARSE_TICKS-th tick period spans CYC_PER_TICK - offset and the others span CYC_PER_TICK.
- R6: The offset is read as a signed two's-complement byte (-128 to +127). Positive values shorten the adjusted period and negative values lengthen it.
- R7: A written value governs only tick periods that start after the next sec_tick. The period in progress keeps the previous value.
- R8: A write whose bits 14:8 differ from {0, ~b7, b7, b7, b7, b7, b7} (b7 = bit 7) sets fill_err from the next cycle. The offset and mode of that write are still applied.
- R9: fill_err stays set until reset. Later writes with a correct fill do not clear it, and correct writes never set it.
- R10: sec_tick is high for exactly one clock cycle per period, in the cycle right after the reference enable that completes the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_en | input | 1 | One-cycle enable per 32768 Hz reference cycle |
| cal_we | input | 1 | Calibration register write strobe |
| cal_wdata | input | 16 | Calibration word to write |
| cal_rdata | output | 16 | Calibration register readback |
| sec_tick | output | 1 | Corrected once-per-second tick enable |
| fill_err | output | 1 | Sticky flag for a write with a wrong bits 14:8 fill |

## Verification
The bench counts reference enables between ticks while the enable arrives with random gaps. This catches a design that counts clocks rather than enables, or one that is off by one cycle on the period. Extreme offsets of +127 and -128 in coarse mode expose a design that sign-extends the byte incorrectly or lets the period arithmetic wrap. Every write is issued just after a tick and the next period is checked against the old value. A design that applies new values immediately would adjust the wrong tick, or start its window count at the wrong point. A wrong-fill write followed by a correct one checks that the error flag is sticky and that the offset is still applied, not dropped.

// File: rtl/rtc_trim_pkg.sv
// Shared constants and helpers for the tick trimmer.
// Assumes the calibration word is 16 bits wide, laid out as the block requires.
package rtc_trim_pkg;
    localparam logic [15:0] CAL_NOMINAL = 16'h2000;

    // True when bits 14:8 carry the sign-dependent fill for bit 7.
    function automatic logic fill_ok(input logic [15:0] w);
        return w[14:8] == {1'b0, ~w[7], {5{w[7]}}};
    endfunction
endpackage

// File: rtl/trim_cal_reg.sv
// Calibration register: holds the written word, flags bad fill, and copies
// the word into the active setting at each tick boundary.
// Assumes cal_we is a one-cycle strobe and load marks the end of a period.
module trim_cal_reg
    import rtc_trim_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cal_we,
    input  logic [15:0] cal_wdata,
    input  logic        load,
    output logic [15:0] shadow,
    output logic [7:0]  act_off,
    output logic        act_coarse,
    output logic        fill_err
);
    logic [15:0] active;

    // Capture writes into the software-visible copy.
    always_ff @(posedge clk) begin
        if (!rst_n)      shadow <= CAL_NOMINAL;
        else if (cal_we) shadow <= cal_wdata;
    end

    // Latch a sticky error on any write with a wrong fill pattern.
    always_ff @(posedge clk) begin
        if (!rst_n)                          fill_err <= 1'b0;
        else if (cal_we && !fill_ok(cal_wdata)) fill_err <= 1'b1;
    end

    // Move the written value into use only at a tick boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)    active <= CAL_NOMINAL;
        else if (load) active <= shadow;
    end

    assign act_off    = active[7:0];
    assign act_coarse = active[15];
endmodule

// File: rtl/trim_window.sv
// Adjustment window: counts ticks and marks the period that carries the
// correction, once every FINE_TICKS or COARSE_TICKS periods.
// Assumes both window lengths are at least 1.
module trim_window #(
    parameter int FINE_TICKS   = 32,
    parameter int COARSE_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic coarse,
    output logic adjust
);
    localparam int MAXW = (FINE_TICKS > COARSE_TICKS) ? FINE_TICKS : COARSE_TICKS;
    localparam int WW   = $clog2(MAXW + 1);
    localparam logic [WW-1:0] FINE_LAST   = WW'(FINE_TICKS - 1);
    localparam logic [WW-1:0] COARSE_LAST = WW'(COARSE_TICKS - 1);

    logic [WW-1:0] win_cnt;
    logic [WW-1:0] last;

    // Pick the last period index of the window for the active mode.
    always_comb last = coarse ? COARSE_LAST : FINE_LAST;

    assign adjust = (win_cnt >= last);

    // Step the window once per completed period, restarting after the adjusted one.
    always_ff @(posedge clk) begin
        if (!rst_n)      win_cnt <= '0;
        else if (wrap)   win_cnt <= adjust ? '0 : win_cnt + 1'b1;
    end
endmodule

// File: rtl/trim_phase.sv
// Phase counter: counts reference enables up to the requested period and
// emits a registered one-cycle tick after the enable that completes it.
// Assumes period is at least 2 and changes only when wrap is high.
module trim_phase #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_en,
    input  logic [PW-1:0] period,
    output logic          wrap,
    output logic          tick
);
    logic [PW-1:0] phase;

    assign wrap = ref_en && (phase == period - {{(PW-1){1'b0}}, 1'b1});

    // Advance the phase on each reference enable and restart at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n)      phase <= '0;
        else if (wrap)   phase <= '0;
        else if (ref_en) phase <= phase + 1'b1;
    end

    // Register the tick so it is a clean single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) tick <= 1'b0;
        else        tick <= wrap;
    end
endmodule

// File: rtl/rtc_trim.sv
// Top of the tick trimmer: joins the calibration register, the adjustment
// window and the phase counter, and computes the period length of each tick.
// Assumes CYC_PER_TICK exceeds 128 so a +127 offset still leaves a valid period.
module rtc_trim #(
    parameter int CYC_PER_TICK = 32768,
    parameter int FINE_TICKS   = 32,
    parameter int COARSE_TICKS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ref_en,
    input  logic        cal_we,
    input  logic [15:0] cal_wdata,
    output logic [15:0] cal_rdata,
    output logic        sec_tick,
    output logic        fill_err
);
    localparam int PW = $clog2(CYC_PER_TICK + 129);
    localparam logic signed [PW:0] BASE_S = (PW+1)'(CYC_PER_TICK);

    logic                 wrap;
    logic                 adjust;
    logic [7:0]           act_off;
    logic                 act_coarse;
    logic signed [PW:0]   off_s;
    logic signed [PW:0]   per_s;
    logic [PW-1:0]        period;

    trim_cal_reg u_cal (
        .clk        (clk),
        .rst_n      (rst_n),
        .cal_we     (cal_we),
        .cal_wdata  (cal_wdata),
        .load       (wrap),
        .shadow     (cal_rdata),
        .act_off    (act_off),
        .act_coarse (act_coarse),
        .fill_err   (fill_err)
    );

    trim_window #(
        .FINE_TICKS   (FINE_TICKS),
        .COARSE_TICKS (COARSE_TICKS)
    ) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap   (wrap),
        .coarse (act_coarse),
        .adjust (adjust)
    );

    // Period of the current tick: nominal, or nominal minus the signed offset.
    always_comb begin
        off_s  = adjust ? $signed({{(PW-7){act_off[7]}}, act_off}) : '0;
        per_s  = BASE_S - off_s;
        period = per_s[PW-1:0];
    end

    trim_phase #(.PW(PW)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_en (ref_en),
        .period (period),
        .wrap   (wrap),
        .tick   (sec_tick)
    );
endmodule

// File: rtl/rtc_trim_chk.sv
// Port-level checker for the tick trimmer, bound onto every instance.
module rtc_trim_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ref_en,
    input logic        cal_we,
    input logic [15:0] cal_wdata,
    input logic [15:0] cal_rdata,
    input logic        sec_tick,
    input logic        fill_err
);
    logic bad_fill;
    assign bad_fill = cal_wdata[14:8] != {1'b0, ~cal_wdata[7], {5{cal_wdata[7]}}};

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (cal_rdata == 16'h2000 && !sec_tick && !fill_err));

    // R2
    readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_we |=> cal_rdata == $past(cal_wdata));

    // R8
    bad_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_we && bad_fill) |=> fill_err);

    // R9
    sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_err |=> fill_err);

    // R10
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);

    // R10
    tick_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sec_tick) |-> $past(ref_en));
endmodule

bind rtc_trim rtc_trim_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_en    (ref_en),
    .cal_we    (cal_we),
    .cal_wdata (cal_wdata),
    .cal_rdata (cal_rdata),
    .sec_tick  (sec_tick),
    .fill_err  (fill_err)
);

// File: tb/rtc_trim_bench.sv
module rtc_trim_bench;
    localparam int BASE   = 256;
    localparam int FINE   = 4;
    localparam int COARSE = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_en = 1'b0;
    logic        cal_we = 1'b0;
    logic [15:0] cal_wdata = '0;
    logic [15:0] cal_rdata;
    logic        sec_tick;
    logic        fill_err;

    int checks = 0;
    int fails  = 0;

    // Bench model of the calibration state.
    logic [15:0] m_shadow = 16'h2000;
    logic [15:0] m_active = 16'h2000;
    int          m_wcnt   = 0;
    int          ref_cnt  = 0;
    logic        last_ref = 1'b0;

    always #10 clk = ~clk;

    rtc_trim #(.CYC_PER_TICK(BASE), .FINE_TICKS(FINE), .COARSE_TICKS(COARSE)) u_rtc_trim (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .cal_we(cal_we),
        .cal_wdata(cal_wdata), .cal_rdata(cal_rdata),
        .sec_tick(sec_tick), .fill_err(fill_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    function automatic logic [15:0] mk(input bit coarse, input logic [7:0] off);
        return {coarse, 1'b0, ~off[7], {5{off[7]}}, off};
    endfunction

    // Expected reference enables in a period, from mode, offset and window position.
    function automatic int exp_period(input logic [15:0] act, input int wcnt);
        int wlen = act[15] ? COARSE : FINE;
        if (wcnt >= wlen - 1) return BASE - int'($signed(act[7:0]));
        return BASE;
    endfunction

    // Drive random reference enables and check n tick periods.
    task automatic run_ticks(input int n, input string req, input string first_req);
        for (int k = 0; k < n; k++) begin
            bit done = 0;
            int guard = 0;
            while (!done) begin
                @(negedge clk);
                if (sec_tick) begin
                    int e = exp_period(m_active, m_wcnt);
                    int wlen = m_active[15] ? COARSE : FINE;
                    check(ref_cnt == e, (k == 0) ? first_req : req, ref_cnt, e);
                    check(last_ref == 1'b1, "R10", int'(last_ref), 1);
                    m_wcnt = (m_wcnt >= wlen - 1) ? 0 : m_wcnt + 1;
                    m_active = m_shadow;
                    ref_cnt = 0;
                    done = 1;
                end
                last_ref = (($urandom % 4) != 0);
                ref_en = last_ref;
                if (last_ref) ref_cnt++;
                guard++;
                if (guard > 4 * (BASE + 200)) begin
                    check(0, req, guard, BASE);
                    done = 1;
                end
            end
        end
    endtask

    // Write a word right after a tick and check the readback.
    task automatic write_cal(input logic [15:0] v);
        @(negedge clk);
        ref_en = 1'b0; last_ref = 1'b0;
        cal_we = 1'b1; cal_wdata = v;
        @(negedge clk);
        cal_we = 1'b0;
        m_shadow = v;
        check(cal_rdata == v, "R2", int'(cal_rdata), int'(v));
    endtask

    initial begin
        #(20 * 200000);
        check(0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(cal_rdata == 16'h2000, "R1", int'(cal_rdata), 16'h2000);
        check(sec_tick == 1'b0, "R1", int'(sec_tick), 0);
        check(fill_err == 1'b0, "R1", int'(fill_err), 0);
        rst_n = 1'b1;

        run_ticks(5, "R3", "R3");
        write_cal(16'h2000);
        run_ticks(3, "R3", "R3");

        write_cal(mk(0, 8'sd5));
        run_ticks(8, "R4", "R7");
        write_cal(mk(0, 8'hF9));
        run_ticks(8, "R6", "R7");
        write_cal(mk(1, 8'd127));
        run_ticks(5, "R5", "R7");
        write_cal(mk(1, 8'h80));
        run_ticks(5, "R6", "R7");

        for (int i = 0; i < 4; i++) begin
            logic [7:0] o = 8'($urandom);
            write_cal(mk(1'($urandom), o));
            run_ticks(5, "R4", "R7");
        end
        check(fill_err == 1'b0, "R9", int'(fill_err), 0);

        write_cal(16'h0005);
        check(fill_err == 1'b1, "R8", int'(fill_err), 1);
        run_ticks(6, "R8", "R7");
        write_cal(mk(1, 8'hF0));
        check(fill_err == 1'b1, "R9", int'(fill_err), 1);
        run_ticks(4, "R5", "R7");

        summary();
    end
endmodule